// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs single management transactions on the two-wire PHY management bus. Software composes one 32-bit management word that holds the start code, the operation, the PHY and register addresses, the turnaround code and sixteen data bits, then writes it through a simple register port. The controller sends an all-ones preamble and then the word, most significant bit first, with one bit per MDC period.

On a write, the controller drives the line for the whole frame. On a read, it releases the line for the turnaround and data phases. It samples the sixteen bits the PHY returns and shifts them into the data field of the same word, so software reads the result back from the register it wrote.

An idle flag is low from the accepted write until the last bit period ends. The MDC period is chosen from a fixed set of system-clock multiples, and the choice is latched when the word is accepted. The management port works only while an enable input is high. Dropping that input ends any frame at once.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, idle_o is 1, mdc_o is 0, mdio_oe_o is 0 and rd_data_o is 0.
- R2: A word is accepted only on a cycle with wr_en_i=1, port_en_i=1 and idle_o=1. It appears on rd_data_o the next cycle, and idle_o is then low for exactly (PRE_LEN+32)*N system cycles, where N is the MDC period.
- R3: The word layout is: bits [31:30] start code 01; bits [29:28] operation, 01 = write and 10 = read; bits [27:23] PHY address; bits [22:18] register address; bits [17:16] turnaround code 10; bits [15:0] data. The serial stream is PRE_LEN (default 32) ones followed by word bits 31 down to 0, one bit per MDC period.
- R4: For a write, mdio_oe_o is 1 for every bit period of the frame. For a read, mdio_oe_o is 0 for the last 18 bit periods (turnaround and data). mdio_oe_o is 0 whenever idle_o is 1.
- R5: For a read, mdio_i is sampled at the MDC rising edge of each of the last 16 bit periods, most significant bit first. The sampled bits replace rd_data_o[15:0], and bits [31:16] are unchanged.
- R6: The MDC period N is chosen by div_sel_i as follows: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 48, 4 gives 64, and 5, 6 or 7 give 96 system cycles. MDC is high for N/2 cycles and low for N/2 cycles. div_sel_i is latched when the word is accepted, and later changes do not affect the running frame. mdc_o stays low while idle.
- R7: mdio_o changes only together with a falling MDC edge, or when the port is disabled. Input sampling happens on the rising edge.
- R8: A write while a frame is running is ignored. The word, and the frame timing, are unchanged.
- R9: While port_en_i is 0, writes are ignored. Dropping port_en_i during a frame ends it on the next clock edge: idle_o becomes 1 and mdc_o and mdio_oe_o become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the management word |
| wr_data_i | input | 32 | Management word to send |
| rd_data_o | output | 32 | Current management word, holding read data after a read |
| port_en_i | input | 1 | Management port enable |
| div_sel_i | input | 3 | MDC period select |
| idle_o | output | 1 | High when no frame is in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach from the ports is the read data phase. Here the PHY value must be valid at the exact MDC rise of each of the last sixteen bit periods, while the controller has already released the line. The bench models the PHY by watching mdc_o rises at the falling system-clock edge and presenting the next reply bit one bit period ahead. This lets a wrong sample edge, bit order or release point show up in the read-back word. Mid-frame writes, a divider change and a dropped enable are injected while idle_o is low, to reach the ignore and abort paths.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 16;
  localparam int TA_W   = 2;
  localparam int CNT_W  = 7;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic [CNT_W-1:0] period_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(16);
      3'd2:    return CNT_W'(32);
      3'd3:    return CNT_W'(48);
      3'd4:    return CNT_W'(64);
      default: return CNT_W'(96);
    endcase
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;

  assign half   = period_i >> 1;
  assign rise_o = run_i && (cnt_q == half - CNT_W'(1));
  assign fall_o = run_i && (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CNT_W'(1);
      if (rise_o)      mdc_o <= 1'b1;
      else if (fall_o) mdc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int PRE_LEN = 32,
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 16,
  parameter int TA_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              is_read_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic              cap_o
);
  localparam int TOTAL = PRE_LEN + WORD_W;
  localparam int BIT_W = $clog2(TOTAL);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(TOTAL - 1);
  localparam logic [BIT_W-1:0] PRE_B  = BIT_W'(PRE_LEN);
  localparam logic [BIT_W-1:0] REL_B  = BIT_W'(TOTAL - DATA_W - TA_W);
  localparam logic [BIT_W-1:0] CAP_B  = BIT_W'(TOTAL - DATA_W);

  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] nxt_b;
  logic [IDX_W-1:0] pos;
  logic             nxt_val;

  assign nxt_b   = bit_q + BIT_W'(1);
  assign pos     = IDX_W'(WORD_W - 1) - IDX_W'(nxt_b - PRE_B);
  assign nxt_val = (nxt_b < PRE_B) ? 1'b1 : word_i[pos];
  assign cap_o   = busy_o && is_read_i && rise_i && (bit_q >= CAP_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      bit_q  <= '0;
      mdio_o <= 1'b1;
      oe_o   <= 1'b0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      bit_q  <= '0;
      mdio_o <= 1'b1;
      oe_o   <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      bit_q  <= '0;
      mdio_o <= 1'b1;
      oe_o   <= 1'b1;
    end else if (busy_o && fall_i) begin
      if (bit_q == LAST_B) begin
        busy_o <= 1'b0;
        mdio_o <= 1'b1;
        oe_o   <= 1'b0;
      end else begin
        bit_q  <= nxt_b;
        mdio_o <= nxt_val;
        oe_o   <= !(is_read_i && (nxt_b >= REL_B));
      end
    end
  end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_frame_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              port_en_i,
  input  logic [2:0]        div_sel_i,
  output logic              idle_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  period_q;
  logic busy, accept, abort, is_read, rise, fall, cap;

  assign accept  = wr_en_i && port_en_i && !busy;
  assign abort   = busy && !port_en_i;
  assign is_read = word_q[WORD_W-3 -: 2] == OP_READ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      period_q <= period_of(3'd0);
    end else if (accept) begin
      word_q   <= wr_data_i;
      period_q <= period_of(div_sel_i);
    end else if (cap) begin
      word_q[DATA_W-1:0] <= {word_q[DATA_W-2:0], mdio_i};
    end
  end

  mdc_divider #(.CNT_W(CNT_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy && port_en_i),
    .period_i (period_q),
    .mdc_o    (mdc_o),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  frame_shifter #(
    .PRE_LEN (PRE_LEN),
    .WORD_W  (WORD_W),
    .DATA_W  (DATA_W),
    .TA_W    (TA_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .abort_i   (abort),
    .is_read_i (is_read),
    .word_i    (word_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .oe_o      (mdio_oe_o),
    .cap_o     (cap)
  );

  assign rd_data_o = word_q;
  assign idle_o    = !busy;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        port_en_i,
  input logic [31:0] rd_data_o,
  input logic        idle_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  assert_start_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> $past(wr_en_i && port_en_i));

  assert_idle_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mdio_oe_o);

  assert_mdc_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mdc_o);

  assert_out_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(mdio_o) |-> ($fell(mdc_o) || $past(!port_en_i)));

  assert_word_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && mdio_oe_o) |=> $stable(rd_data_o));

  assert_disable_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (idle_o && !mdc_o && !mdio_oe_o));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .port_en_i (port_en_i),
  .rd_data_o (rd_data_o),
  .idle_o    (idle_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_frame_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic port_en_i = 1'b1;
  logic [2:0] div_sel_i = '0;
  logic idle_o, mdc_o, mdio_o, mdio_oe_o;
  logic mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;

  // monitor / PHY model state
  logic [63:0] stream, oe_bits;
  logic [15:0] cur_reply = '0;
  logic mdc_prev = 1'b0;
  int rises, dur, hi_run, last_hi;

  always #2.5 clk_i = ~clk_i;

  mdio_frame_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .port_en_i(port_en_i), .div_sel_i(div_sel_i),
    .idle_o(idle_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .mdio_i(mdio_i)
  );

  function automatic logic phy_bit(input int r);
    if (r >= 48 && r < 64) return cur_reply[63-r];
    return 1'b1;
  endfunction

  always @(negedge clk_i) begin
    if (wr_en_i && port_en_i && idle_o) begin
      rises = 0; stream = '0; oe_bits = '0; dur = 0; hi_run = 0; last_hi = 0;
      mdio_i = 1'b1;
    end else begin
      if (!idle_o) dur++;
      if (mdc_o) hi_run++;
      else if (mdc_prev) begin last_hi = hi_run; hi_run = 0; end
      if (mdc_o && !mdc_prev) begin
        stream  = {stream[62:0], mdio_o};
        oe_bits = {oe_bits[62:0], mdio_oe_o};
        rises++;
        mdio_i = phy_bit(rises);
      end
    end
    mdc_prev = mdc_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  function automatic int per(input logic [2:0] s);
    case (s)
      3'd0: return 8;   3'd1: return 16; 3'd2: return 32;
      3'd3: return 48;  3'd4: return 64; default: return 96;
    endcase
  endfunction

  task automatic issue(input logic [31:0] w, input logic [2:0] s);
    @(posedge clk_i); #1;
    wr_data_i = w; div_sel_i = s; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (!idle_o);
  endtask

  // {op, phy, reg, data_or_reply, sel}
  localparam logic [5:0][30:0] VECS = {
    {2'b01, 5'd9,  5'd4,  16'h0000, 3'd5},
    {2'b10, 5'd17, 5'd3,  16'h8000, 3'd4},
    {2'b10, 5'd0,  5'd2,  16'h0001, 3'd3},
    {2'b01, 5'd31, 5'd31, 16'hFFFF, 3'd2},
    {2'b10, 5'd3,  5'd1,  16'hA5C3, 3'd1},
    {2'b01, 5'd1,  5'd0,  16'h1234, 3'd0}
  };

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset", {60'd0, idle_o, mdc_o, mdio_oe_o, 1'b0}, {60'd0, 4'b1000});
    chk("R1 reset word", {32'd0, rd_data_o}, 64'd0);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] op; logic [4:0] ph, rg; logic [15:0] d; logic [2:0] s;
      logic [31:0] w, exp_w; logic [63:0] mask; int n;
      {op, ph, rg, d, s} = VECS[i];
      n = per(s);
      if (op == 2'b10) begin
        w = mk(op, ph, rg, 16'h5A5A); cur_reply = d;
        exp_w = {w[31:16], d}; mask = ~64'h3FFFF;
      end else begin
        w = mk(op, ph, rg, d); cur_reply = 16'h0;
        exp_w = w; mask = '1;
      end
      issue(w, s);
      wait_idle();
      chk("R3 stream", stream & mask, {32'hFFFFFFFF, w} & mask);
      chk("R4 oe pattern", oe_bits, mask);
      chk("R2 duration", 64'(dur), 64'(64 * n));
      chk("R6 mdc high", 64'(last_hi), 64'(n / 2));
      chk("R5 readback", {32'd0, rd_data_o}, {32'd0, exp_w});
      chk("R7 rise count", 64'(rises), 64'd64);
    end

    // R6: select 7 maps to 96
    issue(mk(2'b01, 5'd2, 5'd2, 16'hC0DE), 3'd7);
    wait_idle();
    chk("R6 sel7 duration", 64'(dur), 64'(64 * 96));
    chk("R6 sel7 high", 64'(last_hi), 64'd48);

    // R6: divider change mid-frame ignored
    issue(mk(2'b01, 5'd4, 5'd6, 16'h0F0F), 3'd0);
    div_sel_i = 3'd5;
    wait_idle();
    chk("R6 latched divider", 64'(dur), 64'(512));

    // R8: write while busy ignored
    issue(mk(2'b01, 5'd5, 5'd7, 16'hBEEF), 3'd0);
    repeat (100) @(posedge clk_i); #1;
    wr_data_i = mk(2'b10, 5'd1, 5'd1, 16'h1111); wr_en_i = 1'b1;
    @(posedge clk_i); #1 wr_en_i = 1'b0;
    wait_idle();
    chk("R8 word kept", {32'd0, rd_data_o}, {32'd0, mk(2'b01, 5'd5, 5'd7, 16'hBEEF)});
    chk("R8 timing kept", 64'(dur), 64'(512));

    // R9: write with port disabled ignored
    @(posedge clk_i); #1 port_en_i = 1'b0;
    issue(mk(2'b01, 5'd8, 5'd8, 16'h7777), 3'd0);
    repeat (4) @(negedge clk_i);
    chk("R9 no start", {63'd0, idle_o}, 64'd1);
    chk("R9 word unchanged", {32'd0, rd_data_o}, {32'd0, mk(2'b01, 5'd5, 5'd7, 16'hBEEF)});

    // R9: dropping enable aborts
    @(posedge clk_i); #1 port_en_i = 1'b1;
    issue(mk(2'b01, 5'd3, 5'd3, 16'h3333), 3'd0);
    repeat (37) @(posedge clk_i); #1 port_en_i = 1'b0;
    @(negedge clk_i);
    chk("R9 busy seen", 64'(dur > 30), 64'd1);
    @(negedge clk_i);
    chk("R9 abort", {61'd0, idle_o, mdc_o, mdio_oe_o}, {61'd0, 3'b100});
    @(posedge clk_i); #1 port_en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R4 idle oe low", {63'd0, mdio_oe_o}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule